// File: doc/BRIEF.md
# Reset Cause Status and Control Register

This block holds the reset-cause flags of a host bridge in one 32-bit register within the bridge's configuration space. Software reads it to learn why the system last came out of reset. It clears the hardware-recorded causes by writing ones to them. Setting either software reset cause also asks the system to reset, through a one-cycle request pulse.

The register sits in a byte window from offset `0xF020` through `0xF027`. Both 32-bit words in that window reach the same register. Accesses are 32 bits wide and decode on a 16-bit offset. A hit is acknowledged one cycle after it is presented. A miss receives no acknowledge and changes nothing.

The reset input comes with a cold-start indication. A cold reset loads the register with only the power-on flag set. A warm reset leaves the contents untouched, so software can still see the recorded cause after a reset that it requested itself. The block does not sequence the system reset and does not debounce buttons.

Top module: `rst_cause_reg`

## Requirements
- R1: A reset with `cold_i` high makes the register read `0x80000000`: power-on flag (bit 31) set, bits 30..27 clear.
- R2: A reset with `cold_i` low leaves bits 31..27 exactly as they were before that reset.
- R3: A read hit returns the flags in bits 31..27 of `acc_rdata`, and bits 26..0 are always zero. The bits are: 31 power-on, 30 software power-on, 29 software external, 28 button power-on, 27 button external.
- R4: Writing one to bit 31, 28 or 27 clears that flag, and writing zero there leaves it unchanged. After a cold reset, bits 28 and 27 read zero, and no write ever sets them.
- R5: Writing one to bit 30 or 29 sets that flag, and writing zero there leaves it unchanged. Only a cold reset clears them.
- R6: A write hit with bit 30 of the data set drives `sys_rst_req` high for exactly the one cycle after the write.
- R7: A write hit with bit 30 clear and bit 29 set also pulses `sys_rst_req`. A write hit with neither bit set produces no pulse.
- R8: An access whose offset lies in `0xF020`..`0xF027` gets `acc_ack` high in the next cycle only. An access outside that window gets no acknowledge and changes neither the flags nor `sys_rst_req`.
- R9: `acc_rdata` is zero in every cycle that does not carry a read acknowledge, which includes write acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cold_i | input | 1 | High while `rst_n` is low means this is the first reset after power-up |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_ack | output | 1 | Acknowledge, one cycle after a hit |
| acc_rdata | output | 32 | Read data, valid with `acc_ack` on a read |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
A wrong flag has no effect at the ports until software reads the register, so each write in the bench is followed by reads. The bench also reads after warm and cold resets. A missing or extra reset request shows at `sys_rst_req` in the cycle right after the write. A decode fault shows as an acknowledge that is missing or out of place, or as a flag change after an access outside the window. The bench's reference model compares all three outputs on every clock, so a divergence is caught within one cycle of the access that exposes it.

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
  parameter int WIN_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cold_i,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic              acc_ack,
  output logic [31:0]       acc_rdata,
  output logic              sys_rst_req
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(WIN_BYTES - 1);
  localparam int FLAG_LSB = 27;

  // flags[4]=pwr, [3]=sw pwr, [2]=sw ext, [1]=btn pwr, [0]=btn ext
  logic [4:0] flags;
  logic [4:0] wd;
  logic       hit, wr_hit, rd_hit;
  logic       unused_wd;

  assign wd        = acc_wdata[31:FLAG_LSB];
  assign unused_wd = &{1'b0, acc_wdata[FLAG_LSB-1:0]};
  assign hit       = acc_valid && (acc_addr >= BASE_ADDR) && (acc_addr <= LAST_ADDR);
  assign wr_hit    = hit && acc_write;
  assign rd_hit    = hit && !acc_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (cold_i) flags <= 5'b10000;
      acc_ack     <= 1'b0;
      acc_rdata   <= '0;
      sys_rst_req <= 1'b0;
    end else begin
      acc_ack     <= hit;
      acc_rdata   <= rd_hit ? {flags, {FLAG_LSB{1'b0}}} : '0;
      sys_rst_req <= wr_hit && (wd[3] || wd[2]);
      if (wr_hit) flags <= (flags & ~(wd & 5'b10011)) | (wd & 5'b01100);
    end
  end

  // R4
  pwr_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && acc_wdata[31]) |=> !flags[4]);

  // R5
  sw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> !$fell(flags[3]) && !$fell(flags[2]));

  // R2
  warm_hold_chk: assert property (@(posedge clk)
    (!rst_n && !cold_i) |=> $stable(flags));

  // R6
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(wr_hit && (acc_wdata[30] || acc_wdata[29])));

  // R6
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req || $past(wr_hit));

  // R8
  ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack |-> $past(acc_valid));

  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ack |-> (acc_rdata == 32'h0));
endmodule

// File: tb/rst_cause_reg_tb.sv
module rst_cause_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cold_i = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic        acc_ack;
  logic [31:0] acc_rdata;
  logic        sys_rst_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit started = 1'b0;

  logic [4:0]  m_flags;
  logic        m_ack = 1'b0;
  logic        m_req = 1'b0;
  logic [31:0] m_rdata = '0;

  always #10 clk = ~clk;

  rst_cause_reg u_dut (
    .clk(clk), .rst_n(rst_n), .cold_i(cold_i),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_ack(acc_ack), .acc_rdata(acc_rdata),
    .sys_rst_req(sys_rst_req)
  );

  // behavioural reference model
  always @(posedge clk) begin
    logic h;
    logic [4:0] f;
    f = m_flags;
    if (!rst_n) begin
      if (cold_i) begin f = 5'b10000; started <= 1'b1; end
      m_ack <= 1'b0; m_req <= 1'b0; m_rdata <= '0;
    end else begin
      h = acc_valid && acc_addr >= 16'hF020 && acc_addr <= 16'hF027;
      m_ack   <= h;
      m_rdata <= (h && !acc_write) ? {m_flags, 27'd0} : 32'd0;
      m_req   <= h && acc_write && (acc_wdata[30] || acc_wdata[29]);
      if (h && acc_write) begin
        if (acc_wdata[31]) f[4] = 1'b0;
        if (acc_wdata[30]) f[3] = 1'b1;
        if (acc_wdata[29]) f[2] = 1'b1;
        if (acc_wdata[28]) f[1] = 1'b0;
        if (acc_wdata[27]) f[0] = 1'b0;
      end
    end
    m_flags <= f;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison with the model
  always @(negedge clk) begin
    if (started && !done) begin
      check(acc_ack === m_ack, "R8 ack vs model", {31'd0, acc_ack}, {31'd0, m_ack});
      check(acc_rdata === m_rdata, "R3 rdata vs model", acc_rdata, m_rdata);
      check(sys_rst_req === m_req, "R6 req vs model", {31'd0, sys_rst_req}, {31'd0, m_req});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  logic        s_ack, s_req;
  logic [31:0] s_rdata;

  task automatic access(input bit wr, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    s_ack = acc_ack; s_req = sys_rst_req; s_rdata = acc_rdata;
  endtask

  task automatic rd_expect(input logic [15:0] a, input logic [31:0] exp, input string tag);
    access(1'b0, a, 32'd0);
    check(s_ack === 1'b1, {tag, " ack"}, {31'd0, s_ack}, 32'd1);
    check(s_rdata === exp, tag, s_rdata, exp);
  endtask

  task automatic do_reset(input bit cold);
    @(negedge clk);
    rst_n = 1'b0; cold_i = cold;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; cold_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    do_reset(1'b1);
    check(acc_ack === 1'b0 && sys_rst_req === 1'b0, "R1 outputs idle after reset",
          {30'd0, acc_ack, sys_rst_req}, 32'd0);
    rd_expect(16'hF020, 32'h8000_0000, "R1 cold value");
    rd_expect(16'hF024, 32'h8000_0000, "R8 alias word");
    rd_expect(16'hF027, 32'h8000_0000, "R8 top byte of window");

    access(1'b1, 16'hF020, 32'h4000_0000);
    check(s_ack === 1'b1, "R8 write ack", {31'd0, s_ack}, 32'd1);
    check(s_req === 1'b1, "R6 sw power-on request", {31'd0, s_req}, 32'd1);
    check(s_rdata === 32'd0, "R9 rdata zero on write ack", s_rdata, 32'd0);
    @(negedge clk);
    check(sys_rst_req === 1'b0, "R6 single cycle pulse", {31'd0, sys_rst_req}, 32'd0);
    rd_expect(16'hF020, 32'hC000_0000, "R5 sw power-on set");

    do_reset(1'b0);
    rd_expect(16'hF020, 32'hC000_0000, "R2 warm reset keeps flags");

    access(1'b1, 16'hF024, 32'h8000_0000);
    check(s_req === 1'b0, "R7 no request without sw bits", {31'd0, s_req}, 32'd0);
    rd_expect(16'hF020, 32'h4000_0000, "R4 power-on cleared");

    access(1'b1, 16'hF020, 32'h2000_0000);
    check(s_req === 1'b1, "R7 sw external request", {31'd0, s_req}, 32'd1);
    rd_expect(16'hF020, 32'h6000_0000, "R5 sw external set");

    access(1'b1, 16'hF020, 32'h0000_0000);
    check(s_req === 1'b0, "R7 zero write no request", {31'd0, s_req}, 32'd0);
    rd_expect(16'hF020, 32'h6000_0000, "R5 zero write keeps flags");

    access(1'b1, 16'hF020, 32'h9FFF_FFFF);
    rd_expect(16'hF020, 32'h6000_0000, "R4 w1c bits cannot set, sw bits stay");

    access(1'b1, 16'hF028, 32'hFFFF_FFFF);
    check(s_ack === 1'b0 && s_req === 1'b0, "R8 miss above window",
          {30'd0, s_ack, s_req}, 32'd0);
    access(1'b0, 16'hF01F, 32'd0);
    check(s_ack === 1'b0 && s_rdata === 32'd0, "R8 miss below window", s_rdata, 32'd0);
    rd_expect(16'hF020, 32'h6000_0000, "R8 miss left flags");

    access(1'b1, 16'hF020, 32'h6000_0000);
    check(s_req === 1'b1, "R6 both sw bits request", {31'd0, s_req}, 32'd1);

    do_reset(1'b1);
    rd_expect(16'hF020, 32'h8000_0000, "R1 second cold reset");
    rd_expect(16'hF023, 32'h8000_0000, "R3 low bits zero");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule